// File: doc/BRIEF.md
# Parallel Bus Master Cycle Engine

This block runs single read and write cycles on an external 8-bit or 16-bit parallel bus. A host loads an address register and then starts a cycle. It starts a write by presenting write data with a start pulse, or a read with a read pulse. The engine then walks the cycle through a fixed order of phases: optional address-latch phases, a data setup phase, a strobe phase and a data hold phase. It drives the address pins, the data pins with their output enable, the read and write strobes, two chip-select pins and two address-latch strobes.

Each of the setup, strobe and hold phases has its own programmable length. The address can sit on dedicated pins or be multiplexed onto the data pins in three ways. The two chip-select pins can carry upper address bits or act as real chip selects. After each cycle the address can stay put, count up or count down. A busy output covers the whole cycle. An optional one-cycle interrupt pulse marks its end. Every strobe and chip select has its own polarity control.

Top module: `pbus_master`

## Requirements
- R1: After reset, busy and irq are 0, the address register is 0, bus_doe is 0, and every strobe, chip-select and latch pin rests at its inactive level, which is the inverse of its polarity bit.
- R2: The setup phase lasts cfg_setup+1 clock cycles (encoding 0 gives 1 cycle, 3 gives 4 cycles). It follows the address phases, and no strobe is active during it.
- R3: The read strobe (for reads) or the write strobe (for writes) is active for cfg_strobe+1 consecutive cycles, from 1 to 16. The two strobes are never active together.
- R4: After the strobe, the hold phase lasts cfg_hold+1 cycles for a write and cfg_hold cycles for a read. A read with cfg_hold=0 ends right at the end of the strobe.
- R5: cfg_mux selects the address layout. 0: address on bus_addr[13:0], with no address phase. 1: one latch phase with address bits 7:0 on bus_dout[7:0] and bus_all active, while address bits 13:8 sit on bus_addr[13:8]. 2: a bus_all phase with address bits 7:0 on bus_dout, then a bus_alh phase with address bits 13:8 on bus_dout. 3: one bus_all phase with address bits 13:0 on bus_dout. Each latch phase lasts exactly one cycle.
- R6: Address register bits 13:0 hold the address, and bits 14 and 15 are the chip-select bits. cfg_csf selects how the chip-select pins behave. 0: bus_cs1 and bus_cs2 output raw register bits 14 and 15. 1: bus_cs1 outputs raw bit 14, and bus_cs2 is a chip select enabled by bit 15. 2 or 3: bus_cs1 and bus_cs2 are chip selects enabled by bits 14 and 15. A chip select is active during the setup, strobe and hold phases.
- R7: At the end of each cycle the address is stepped. With cfg_incm=0 it does not change, with 1 it increments and with 2 it decrements. The step wraps within bits 15:0 for cfg_csf=0, within bits 14:0 for cfg_csf=1 and within bits 13:0 otherwise, and it leaves the bits above that range unchanged.
- R8: busy rises in the cycle after an accepted start and falls at the end of the last phase. While busy is high, wr_start, rd_start and addr_load have no effect: the cycle in progress keeps its data, no second cycle follows, and the address is not reloaded.
- R9: With cfg_irq_en=1, irq pulses high for exactly one cycle, in the first cycle after busy falls. With cfg_irq_en=0, irq stays 0.
- R10: A read captures bus_din into rd_data on the clock edge that ends the strobe, so later changes to bus_din do not affect it. With cfg_wide=0 the captured value is zero-extended from bits 7:0.
- R11: During the data phases of a write, bus_doe is 1 and bus_dout carries the write data. With cfg_wide=0, bus_dout[15:8] is 0.
- R12: Each pin's polarity bit (cfg_pol_rd, cfg_pol_wr, cfg_pol_cs1, cfg_pol_cs2, cfg_pol_al) set to 1 makes that pin active high, and set to 0 makes it active low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_setup | input | 2 | Setup length minus one |
| cfg_strobe | input | 4 | Strobe length minus one |
| cfg_hold | input | 2 | Hold length code (write: minus one, read: direct) |
| cfg_mux | input | 2 | Address/data layout select |
| cfg_csf | input | 2 | Chip-select pin function |
| cfg_incm | input | 2 | Address step mode |
| cfg_wide | input | 1 | 1 = 16-bit transfers, 0 = 8-bit |
| cfg_irq_en | input | 1 | End-of-cycle interrupt enable |
| cfg_pol_rd | input | 1 | Read strobe polarity (1 = active high) |
| cfg_pol_wr | input | 1 | Write strobe polarity |
| cfg_pol_cs1 | input | 1 | Chip select 1 polarity |
| cfg_pol_cs2 | input | 1 | Chip select 2 polarity |
| cfg_pol_al | input | 1 | Address latch strobe polarity |
| addr_load | input | 1 | Load address register from addr_wdata |
| addr_wdata | input | 16 | Address (13:0) and chip-select bits (15:14) |
| wr_start | input | 1 | Start a write cycle with wr_data |
| wr_data | input | 16 | Write data |
| rd_start | input | 1 | Start a read cycle |
| bus_din | input | 16 | Data pins input |
| busy | output | 1 | Cycle in progress |
| irq | output | 1 | End-of-cycle pulse |
| rd_data | output | 16 | Last captured read data |
| bus_addr | output | 16 | Address pins |
| bus_dout | output | 16 | Data pins output value |
| bus_doe | output | 1 | Data pins output enable |
| bus_rd | output | 1 | Read strobe pin |
| bus_wr | output | 1 | Write strobe pin |
| bus_cs1 | output | 1 | Chip select 1 / address bit 14 pin |
| bus_cs2 | output | 1 | Chip select 2 / address bit 15 pin |
| bus_all | output | 1 | Low address latch strobe |
| bus_alh | output | 1 | High address latch strobe |

## Verification
The cycle engine is run with reads and writes that combine minimum, maximum and mixed phase lengths with all four address layouts. Counting the cycles before, during and after the strobe therefore separates a wrong setup count, a wrong strobe count, and the different off-by-one rule that holds use for reads and writes. The values sampled during the latch phases show whether each layout puts the right address part on the data pins. Directed cases then cover address wrap in each stepping width, chip-select layouts, narrow transfers, pin polarities, requests made while busy, and changes to the input data after the strobe ends.

// File: rtl/pbus_pkg.sv
package pbus_pkg;

    typedef enum logic [2:0] {
        PH_IDLE  = 3'd0,
        PH_ALO   = 3'd1,
        PH_AHI   = 3'd2,
        PH_SETUP = 3'd3,
        PH_STRB  = 3'd4,
        PH_HOLD  = 3'd5
    } phase_e;

    typedef enum logic [1:0] {
        MX_SPLIT  = 2'd0,
        MX_LOBYTE = 2'd1,
        MX_BYTE2  = 2'd2,
        MX_WORD   = 2'd3
    } mux_e;

    typedef enum logic [1:0] {
        CF_ADDR2   = 2'd0,
        CF_CS2ONLY = 2'd1,
        CF_CSBOTH  = 2'd2,
        CF_CSALT   = 2'd3
    } csf_e;

    typedef enum logic [1:0] {
        IN_KEEP = 2'd0,
        IN_UP   = 2'd1,
        IN_DOWN = 2'd2,
        IN_RSVD = 2'd3
    } incm_e;

endpackage

// File: rtl/pbus_seq.sv
module pbus_seq import pbus_pkg::*; #(
    parameter int SU_W  = 2,
    parameter int STB_W = 4,
    parameter int HD_W  = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             start_wr,
    input  logic [1:0]       mux_sel,
    input  logic [SU_W-1:0]  setup_n,
    input  logic [STB_W-1:0] strobe_n,
    input  logic [HD_W-1:0]  hold_n,
    output phase_e           phase,
    output logic             is_wr,
    output logic             capture,
    output logic             finish
);

    localparam int CNT_W = (STB_W > SU_W) ? ((STB_W > HD_W) ? STB_W : HD_W)
                                          : ((SU_W > HD_W) ? SU_W : HD_W);

    typedef struct packed {
        phase_e           ph;
        logic             wr;
        logic [CNT_W-1:0] cnt;
    } seq_t;

    seq_t seq_q, seq_d;

    always_comb begin
        seq_d   = seq_q;
        capture = 1'b0;
        finish  = 1'b0;
        case (seq_q.ph)
            PH_IDLE: begin
                if (start) begin
                    seq_d.wr = start_wr;
                    if (mux_sel == MX_SPLIT) begin
                        seq_d.ph  = PH_SETUP;
                        seq_d.cnt = CNT_W'(setup_n);
                    end else begin
                        seq_d.ph  = PH_ALO;
                        seq_d.cnt = '0;
                    end
                end
            end
            PH_ALO: begin
                if (mux_sel == MX_BYTE2) begin
                    seq_d.ph  = PH_AHI;
                    seq_d.cnt = '0;
                end else begin
                    seq_d.ph  = PH_SETUP;
                    seq_d.cnt = CNT_W'(setup_n);
                end
            end
            PH_AHI: begin
                seq_d.ph  = PH_SETUP;
                seq_d.cnt = CNT_W'(setup_n);
            end
            PH_SETUP: begin
                if (seq_q.cnt == '0) begin
                    seq_d.ph  = PH_STRB;
                    seq_d.cnt = CNT_W'(strobe_n);
                end else begin
                    seq_d.cnt = seq_q.cnt - CNT_W'(1);
                end
            end
            PH_STRB: begin
                if (seq_q.cnt == '0) begin
                    capture = !seq_q.wr;
                    if (seq_q.wr || (hold_n != '0)) begin
                        seq_d.ph  = PH_HOLD;
                        seq_d.cnt = seq_q.wr ? CNT_W'(hold_n)
                                             : CNT_W'(hold_n) - CNT_W'(1);
                    end else begin
                        seq_d.ph = PH_IDLE;
                        finish   = 1'b1;
                    end
                end else begin
                    seq_d.cnt = seq_q.cnt - CNT_W'(1);
                end
            end
            PH_HOLD: begin
                if (seq_q.cnt == '0) begin
                    seq_d.ph = PH_IDLE;
                    finish   = 1'b1;
                end else begin
                    seq_d.cnt = seq_q.cnt - CNT_W'(1);
                end
            end
            default: seq_d.ph = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seq_q <= '{ph: PH_IDLE, wr: 1'b0, cnt: '0};
        end else begin
            seq_q <= seq_d;
        end
    end

    assign phase = seq_q.ph;
    assign is_wr = seq_q.wr;

    AST_BUSY_ON: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_q.ph == PH_IDLE && start) |=> (seq_q.ph != PH_IDLE)); // R8

    AST_STRB_AFTER_SETUP: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_q.ph == PH_STRB && $past(seq_q.ph) != PH_STRB) |-> ($past(seq_q.ph) == PH_SETUP)); // R2

    AST_FINISH_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        finish |=> (seq_q.ph == PH_IDLE)); // R4

endmodule

// File: rtl/pbus_addr.sv
module pbus_addr import pbus_pkg::*; #(
    parameter int ADDR_W = 14
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [ADDR_W+1:0] load_val,
    input  logic              step,
    input  logic [1:0]        incm,
    input  logic [1:0]        csf,
    output logic [ADDR_W+1:0] addr
);

    localparam int REG_W = ADDR_W + 2;
    localparam logic [REG_W-1:0] SPAN_ALL = '1;
    localparam logic [REG_W-1:0] SPAN_MID = {1'b0, {(REG_W-1){1'b1}}};
    localparam logic [REG_W-1:0] SPAN_LOW = {2'b00, {ADDR_W{1'b1}}};

    logic [REG_W-1:0] addr_q, addr_d, span;

    always_comb begin
        case (csf)
            CF_ADDR2:   span = SPAN_ALL;
            CF_CS2ONLY: span = SPAN_MID;
            default:    span = SPAN_LOW;
        endcase
        addr_d = addr_q;
        if (load) begin
            addr_d = load_val;
        end else if (step) begin
            case (incm)
                IN_UP:   addr_d = (addr_q & ~span) | ((addr_q + REG_W'(1)) & span);
                IN_DOWN: addr_d = (addr_q & ~span) | ((addr_q - REG_W'(1)) & span);
                default: addr_d = addr_q;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_q <= '0;
        end else begin
            addr_q <= addr_d;
        end
    end

    assign addr = addr_q;

    AST_ADDR_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && !step) |=> $stable(addr_q)); // R7

    AST_CS_BITS_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && step && csf[1]) |=> (addr_q[REG_W-1:REG_W-2] == $past(addr_q[REG_W-1:REG_W-2]))); // R7

endmodule

// File: rtl/pbus_pins.sv
module pbus_pins import pbus_pkg::*; #(
    parameter int DATA_W = 16,
    parameter int ADDR_W = 14
) (
    input  phase_e            phase,
    input  logic              is_wr,
    input  logic [ADDR_W+1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [1:0]        mux_sel,
    input  logic [1:0]        csf,
    input  logic              wide,
    input  logic              pol_rd,
    input  logic              pol_wr,
    input  logic              pol_cs1,
    input  logic              pol_cs2,
    input  logic              pol_al,
    output logic [ADDR_W+1:0] pin_addr,
    output logic [DATA_W-1:0] pin_dout,
    output logic              pin_doe,
    output logic              pin_rd,
    output logic              pin_wr,
    output logic              pin_cs1,
    output logic              pin_cs2,
    output logic              pin_all,
    output logic              pin_alh
);

    localparam int REG_W  = ADDR_W + 2;
    localparam int HALF_W = DATA_W / 2;

    logic data_ph, rd_act, wr_act, cs1_en, cs2_en;

    always_comb begin
        data_ph = (phase == PH_SETUP) || (phase == PH_STRB) || (phase == PH_HOLD);
        rd_act  = (phase == PH_STRB) && !is_wr;
        wr_act  = (phase == PH_STRB) && is_wr;
        cs1_en  = data_ph && addr[ADDR_W];
        cs2_en  = data_ph && addr[ADDR_W+1];

        pin_rd  = rd_act ~^ pol_rd;
        pin_wr  = wr_act ~^ pol_wr;
        pin_all = (phase == PH_ALO) ~^ pol_al;
        pin_alh = (phase == PH_AHI) ~^ pol_al;

        case (csf)
            CF_ADDR2: begin
                pin_cs1 = addr[ADDR_W];
                pin_cs2 = addr[ADDR_W+1];
            end
            CF_CS2ONLY: begin
                pin_cs1 = addr[ADDR_W];
                pin_cs2 = cs2_en ~^ pol_cs2;
            end
            default: begin
                pin_cs1 = cs1_en ~^ pol_cs1;
                pin_cs2 = cs2_en ~^ pol_cs2;
            end
        endcase

        case (mux_sel)
            MX_SPLIT:  pin_addr = REG_W'(addr[ADDR_W-1:0]);
            MX_LOBYTE: pin_addr = {{(REG_W-ADDR_W){1'b0}}, addr[ADDR_W-1:HALF_W], {HALF_W{1'b0}}};
            default:   pin_addr = '0;
        endcase

        pin_dout = '0;
        pin_doe  = 1'b0;
        if (phase == PH_ALO) begin
            pin_doe  = 1'b1;
            pin_dout = (mux_sel == MX_WORD) ? DATA_W'(addr[ADDR_W-1:0])
                                            : DATA_W'(addr[HALF_W-1:0]);
        end else if (phase == PH_AHI) begin
            pin_doe  = 1'b1;
            pin_dout = DATA_W'(addr[ADDR_W-1:HALF_W]);
        end else if (data_ph && is_wr) begin
            pin_doe  = 1'b1;
            pin_dout = wide ? wdata : DATA_W'(wdata[HALF_W-1:0]);
        end
    end

endmodule

// File: rtl/pbus_master.sv
module pbus_master import pbus_pkg::*; #(
    parameter int DATA_W = 16,
    parameter int ADDR_W = 14,
    parameter int SU_W   = 2,
    parameter int STB_W  = 4,
    parameter int HD_W   = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [SU_W-1:0]   cfg_setup,
    input  logic [STB_W-1:0]  cfg_strobe,
    input  logic [HD_W-1:0]   cfg_hold,
    input  logic [1:0]        cfg_mux,
    input  logic [1:0]        cfg_csf,
    input  logic [1:0]        cfg_incm,
    input  logic              cfg_wide,
    input  logic              cfg_irq_en,
    input  logic              cfg_pol_rd,
    input  logic              cfg_pol_wr,
    input  logic              cfg_pol_cs1,
    input  logic              cfg_pol_cs2,
    input  logic              cfg_pol_al,
    input  logic              addr_load,
    input  logic [ADDR_W+1:0] addr_wdata,
    input  logic              wr_start,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd_start,
    input  logic [DATA_W-1:0] bus_din,
    output logic              busy,
    output logic              irq,
    output logic [DATA_W-1:0] rd_data,
    output logic [ADDR_W+1:0] bus_addr,
    output logic [DATA_W-1:0] bus_dout,
    output logic              bus_doe,
    output logic              bus_rd,
    output logic              bus_wr,
    output logic              bus_cs1,
    output logic              bus_cs2,
    output logic              bus_all,
    output logic              bus_alh
);

    localparam int REG_W  = ADDR_W + 2;
    localparam int HALF_W = DATA_W / 2;

    typedef struct packed {
        logic [DATA_W-1:0] wdata;
        logic [DATA_W-1:0] rdata;
        logic              irq;
    } top_t;

    top_t st_q, st_d;

    phase_e           phase;
    logic             is_wr, capture, finish, start_ok;
    logic [REG_W-1:0] addr_cur;

    assign busy     = (phase != PH_IDLE);
    assign start_ok = (wr_start || rd_start) && !busy;

    pbus_seq #(.SU_W(SU_W), .STB_W(STB_W), .HD_W(HD_W)) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (start_ok),
        .start_wr (wr_start),
        .mux_sel  (cfg_mux),
        .setup_n  (cfg_setup),
        .strobe_n (cfg_strobe),
        .hold_n   (cfg_hold),
        .phase    (phase),
        .is_wr    (is_wr),
        .capture  (capture),
        .finish   (finish)
    );

    pbus_addr #(.ADDR_W(ADDR_W)) u_addr (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (addr_load && !busy),
        .load_val (addr_wdata),
        .step     (finish),
        .incm     (cfg_incm),
        .csf      (cfg_csf),
        .addr     (addr_cur)
    );

    pbus_pins #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_pins (
        .phase    (phase),
        .is_wr    (is_wr),
        .addr     (addr_cur),
        .wdata    (st_q.wdata),
        .mux_sel  (cfg_mux),
        .csf      (cfg_csf),
        .wide     (cfg_wide),
        .pol_rd   (cfg_pol_rd),
        .pol_wr   (cfg_pol_wr),
        .pol_cs1  (cfg_pol_cs1),
        .pol_cs2  (cfg_pol_cs2),
        .pol_al   (cfg_pol_al),
        .pin_addr (bus_addr),
        .pin_dout (bus_dout),
        .pin_doe  (bus_doe),
        .pin_rd   (bus_rd),
        .pin_wr   (bus_wr),
        .pin_cs1  (bus_cs1),
        .pin_cs2  (bus_cs2),
        .pin_all  (bus_all),
        .pin_alh  (bus_alh)
    );

    always_comb begin
        st_d = st_q;
        if (wr_start && !busy) begin
            st_d.wdata = wr_data;
        end
        if (capture) begin
            st_d.rdata = cfg_wide ? bus_din : DATA_W'(bus_din[HALF_W-1:0]);
        end
        st_d.irq = finish && cfg_irq_en;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{wdata: '0, rdata: '0, irq: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    assign irq     = st_q.irq;
    assign rd_data = st_q.rdata;

    AST_IRQ_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        irq |=> !irq); // R9

    AST_IRQ_AFTER_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (!busy && $past(busy))); // R9

    AST_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && wr_start) |=> $stable(st_q.wdata)); // R8

    AST_IDLE_PINS: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> ((bus_rd == !cfg_pol_rd) && (bus_wr == !cfg_pol_wr) && !bus_doe)); // R12

endmodule

// File: tb/sim_pbus_master.sv
module sim_pbus_master;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  cfg_setup = '0;
    logic [3:0]  cfg_strobe = '0;
    logic [1:0]  cfg_hold = '0;
    logic [1:0]  cfg_mux = '0;
    logic [1:0]  cfg_csf = 2'd2;
    logic [1:0]  cfg_incm = '0;
    logic        cfg_wide = 1'b1;
    logic        cfg_irq_en = 1'b1;
    logic        cfg_pol_rd = 1'b0;
    logic        cfg_pol_wr = 1'b0;
    logic        cfg_pol_cs1 = 1'b0;
    logic        cfg_pol_cs2 = 1'b0;
    logic        cfg_pol_al = 1'b1;
    logic        addr_load = 1'b0;
    logic [15:0] addr_wdata = '0;
    logic        wr_start = 1'b0;
    logic [15:0] wr_data = '0;
    logic        rd_start = 1'b0;
    logic [15:0] bus_din = '0;
    logic        busy, irq, bus_doe, bus_rd, bus_wr, bus_cs1, bus_cs2, bus_all, bus_alh;
    logic [15:0] rd_data, bus_addr, bus_dout;

    int checks = 0;
    int errors = 0;

    int pre_n, stb_n, post_n, all_n, alh_n;
    logic [15:0] lo_d, hi_d, stb_dout;
    logic cs1_s, cs2_s, rd_s, irq_s;

    always #10 clk = ~clk;

    pbus_master u0 (
        .clk(clk), .rst_n(rst_n), .cfg_setup(cfg_setup), .cfg_strobe(cfg_strobe),
        .cfg_hold(cfg_hold), .cfg_mux(cfg_mux), .cfg_csf(cfg_csf), .cfg_incm(cfg_incm),
        .cfg_wide(cfg_wide), .cfg_irq_en(cfg_irq_en), .cfg_pol_rd(cfg_pol_rd),
        .cfg_pol_wr(cfg_pol_wr), .cfg_pol_cs1(cfg_pol_cs1), .cfg_pol_cs2(cfg_pol_cs2),
        .cfg_pol_al(cfg_pol_al), .addr_load(addr_load), .addr_wdata(addr_wdata),
        .wr_start(wr_start), .wr_data(wr_data), .rd_start(rd_start), .bus_din(bus_din),
        .busy(busy), .irq(irq), .rd_data(rd_data), .bus_addr(bus_addr), .bus_dout(bus_dout),
        .bus_doe(bus_doe), .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_cs1(bus_cs1),
        .bus_cs2(bus_cs2), .bus_all(bus_all), .bus_alh(bus_alh)
    );

    typedef struct packed {
        logic       wr;
        logic [1:0] su;
        logic [3:0] st;
        logic [1:0] hd;
        logic [1:0] mx;
        logic [4:0] e_pre;
        logic [4:0] e_stb;
        logic [2:0] e_post;
        logic [1:0] e_all;
        logic [1:0] e_alh;
    } vec_t;

    localparam vec_t VECS [8] = '{
        '{1'b1, 2'd0, 4'd0,  2'd0, 2'd0, 5'd1, 5'd1,  3'd1, 2'd0, 2'd0},
        '{1'b1, 2'd3, 4'd15, 2'd3, 2'd0, 5'd4, 5'd16, 3'd4, 2'd0, 2'd0},
        '{1'b0, 2'd1, 4'd2,  2'd0, 2'd0, 5'd2, 5'd3,  3'd0, 2'd0, 2'd0},
        '{1'b0, 2'd2, 4'd5,  2'd3, 2'd0, 5'd3, 5'd6,  3'd3, 2'd0, 2'd0},
        '{1'b1, 2'd0, 4'd1,  2'd1, 2'd1, 5'd2, 5'd2,  3'd2, 2'd1, 2'd0},
        '{1'b0, 2'd1, 4'd0,  2'd2, 2'd2, 5'd4, 5'd1,  3'd2, 2'd1, 2'd1},
        '{1'b1, 2'd2, 4'd3,  2'd0, 2'd3, 5'd4, 5'd4,  3'd1, 2'd1, 2'd0},
        '{1'b0, 2'd0, 4'd7,  2'd1, 2'd3, 5'd2, 5'd8,  3'd1, 2'd1, 2'd0}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic logic strobe_on();
        return ((bus_rd ~^ cfg_pol_rd) == 1'b1) || ((bus_wr ~^ cfg_pol_wr) == 1'b1);
    endfunction

    task automatic load_addr(input logic [15:0] v);
        @(negedge clk);
        addr_load = 1'b1;
        addr_wdata = v;
        @(negedge clk);
        addr_load = 1'b0;
    endtask

    task automatic run_cycle(input logic wr);
        int n;
        logic seen;
        pre_n = 0; stb_n = 0; post_n = 0; all_n = 0; alh_n = 0;
        seen = 1'b0;
        @(negedge clk);
        if (wr) wr_start = 1'b1; else rd_start = 1'b1;
        @(negedge clk);
        wr_start = 1'b0;
        rd_start = 1'b0;
        n = 0;
        while (busy && n < 100) begin
            if (strobe_on()) begin
                stb_n++;
                seen = 1'b1;
                stb_dout = bus_dout;
                cs1_s = bus_cs1;
                cs2_s = bus_cs2;
                rd_s = bus_rd;
            end else if (!seen) begin
                pre_n++;
            end else begin
                post_n++;
                if (!wr && post_n == 1) bus_din = 16'hFFFF;
            end
            if ((bus_all ~^ cfg_pol_al) == 1'b1) begin all_n++; lo_d = bus_dout; end
            if ((bus_alh ~^ cfg_pol_al) == 1'b1) begin alh_n++; hi_d = bus_dout; end
            @(negedge clk);
            n++;
        end
        chk("R8 cycle ends", 32'(n < 100), 32'd1);
        irq_s = irq;
    endtask

    initial begin
        #(20 * 100000);
        errors++;
        $display("FAIL watchdog actual hung expected done");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 busy", 32'(busy), 32'd0);
        chk("R1 irq", 32'(irq), 32'd0);
        chk("R1 addr", 32'(bus_addr), 32'd0);
        chk("R1 doe", 32'(bus_doe), 32'd0);
        chk("R1 pins", {26'd0, bus_rd, bus_wr, bus_cs1, bus_cs2, bus_all, bus_alh}, 32'b111100);

        // table walk: R2 R3 R4 R5 R9 R10 R11
        load_addr(16'h1234);
        wr_data = 16'hA5C3;
        foreach (VECS[i]) begin
            cfg_setup = VECS[i].su;
            cfg_strobe = VECS[i].st;
            cfg_hold = VECS[i].hd;
            cfg_mux = VECS[i].mx;
            bus_din = 16'h5A3C;
            run_cycle(VECS[i].wr);
            chk("R2 setup", 32'(pre_n), 32'(VECS[i].e_pre));
            chk("R3 strobe", 32'(stb_n), 32'(VECS[i].e_stb));
            chk("R4 hold", 32'(post_n), 32'(VECS[i].e_post));
            chk("R5 low latch", 32'(all_n), 32'(VECS[i].e_all));
            chk("R5 high latch", 32'(alh_n), 32'(VECS[i].e_alh));
            chk("R9 irq", 32'(irq_s), 32'd1);
            if (VECS[i].mx == 2'd1 || VECS[i].mx == 2'd2) chk("R5 low byte", 32'(lo_d), 32'h0034);
            if (VECS[i].mx == 2'd2) chk("R5 high byte", 32'(hi_d), 32'h0012);
            if (VECS[i].mx == 2'd3) chk("R5 word", 32'(lo_d), 32'h1234);
            if (VECS[i].wr) chk("R11 data", 32'(stb_dout), 32'hA5C3);
            else chk("R10 read", 32'(rd_data), 32'h5A3C);
        end

        cfg_setup = 2'd0; cfg_strobe = 4'd1; cfg_hold = 2'd0; cfg_mux = 2'd0;

        // R6 chip selects
        cfg_csf = 2'd2; load_addr(16'h8055); run_cycle(1'b1);
        chk("R6 csf2 cs2", 32'(cs2_s), 32'd0);
        chk("R6 csf2 cs1", 32'(cs1_s), 32'd1);
        cfg_csf = 2'd1; load_addr(16'hC000); run_cycle(1'b1);
        chk("R6 csf1 cs2", 32'(cs2_s), 32'd0);
        chk("R6 csf1 cs1 raw", 32'(bus_cs1), 32'd1);
        cfg_csf = 2'd0; load_addr(16'h4000); @(negedge clk);
        chk("R6 csf0 pins", {30'd0, bus_cs2, bus_cs1}, 32'b01);

        // R7 stepping
        cfg_incm = 2'd1; cfg_csf = 2'd2; load_addr(16'h3FFF); run_cycle(1'b1);
        chk("R7 wrap 14", 32'(bus_addr), 32'h0000);
        cfg_csf = 2'd0; load_addr(16'h3FFF); run_cycle(1'b1);
        chk("R7 carry 16 addr", 32'(bus_addr), 32'h0000);
        chk("R7 carry 16 bit14", 32'(bus_cs1), 32'd1);
        cfg_incm = 2'd2; cfg_csf = 2'd2; load_addr(16'h0000); run_cycle(1'b0);
        chk("R7 decrement", 32'(bus_addr), 32'h3FFF);
        cfg_incm = 2'd0; run_cycle(1'b1);
        chk("R7 keep", 32'(bus_addr), 32'h3FFF);

        // R8 requests while busy
        load_addr(16'h0100);
        cfg_setup = 2'd3; cfg_strobe = 4'd3;
        @(negedge clk); wr_data = 16'h1111; wr_start = 1'b1;
        @(negedge clk); wr_start = 1'b0;
        chk("R8 busy rises", 32'(busy), 32'd1);
        @(negedge clk);
        wr_start = 1'b1; wr_data = 16'h2222; rd_start = 1'b1;
        addr_load = 1'b1; addr_wdata = 16'h0200;
        @(negedge clk);
        wr_start = 1'b0; rd_start = 1'b0; addr_load = 1'b0;
        for (int k = 0; k < 40 && busy; k++) begin
            if (strobe_on()) stb_dout = bus_dout;
            @(negedge clk);
        end
        chk("R8 data kept", 32'(stb_dout), 32'h1111);
        @(negedge clk);
        chk("R8 no second cycle", 32'(busy), 32'd0);
        chk("R8 addr kept", 32'(bus_addr), 32'h0100);
        cfg_setup = 2'd0; cfg_strobe = 4'd1;

        // R9 interrupt disabled
        cfg_irq_en = 1'b0; run_cycle(1'b1);
        chk("R9 irq off", 32'(irq_s), 32'd0);
        cfg_irq_en = 1'b1;

        // R10 R11 narrow transfers
        cfg_wide = 1'b0; wr_data = 16'hBEEF; run_cycle(1'b1);
        chk("R11 narrow write", 32'(stb_dout), 32'h00EF);
        bus_din = 16'h1234; run_cycle(1'b0);
        chk("R10 narrow read", 32'(rd_data), 32'h0034);
        cfg_wide = 1'b1;

        // R12 polarity
        cfg_pol_rd = 1'b1; cfg_pol_cs2 = 1'b1; load_addr(16'h8000);
        @(negedge clk);
        chk("R12 rd idle", 32'(bus_rd), 32'd0);
        chk("R12 cs2 idle", 32'(bus_cs2), 32'd0);
        run_cycle(1'b0);
        chk("R12 rd active", 32'(rd_s), 32'd1);
        chk("R12 cs2 active", 32'(cs2_s), 32'd1);
        chk("R12 strobe len", 32'(stb_n), 32'd2);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule